// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is the slave-side control of a general-purpose up-counting timer. It takes three raw inputs: a channel-1 input pin, an external clock pin, and an internal link input driven by a companion timer. It decides when the counter is enabled and which event advances it. Each raw input passes through a polarity stage, a two-flop resynchronizer and a rising-edge detector. The external clock path then passes through a divide-by-1/2/4/8 edge prescaler.

A selected trigger event can start the counter. That event can also be the counter's clock. A third option is to clock the counter from the conditioned external pin, and this option can be combined with the trigger start. Software controls the block through static configuration fields and three single-cycle strobes: start, stop, and clear the trigger flag.

Control is a two-state machine. HALT is the reset state, in which the counter holds. RUN is the counting state. The transition HALT→RUN is named *start*: a start strobe, or a selected trigger edge while in trigger mode, with no stop strobe in the same cycle. The transition RUN→HALT is named *stop*: a stop strobe. In every other case the state holds (*stay*).

Top module: `tim_slave_ctrl`

## Requirements
- R1: After reset the count is 0, `cnt_en` is 0 and `trig_flag` is 0.
- R2: With `cfg_ext_en`=1 and the machine in RUN, the count advances once per active edge of `xclk_in`. The active edge is rising when `cfg_ext_inv`=0 and falling when `cfg_ext_inv`=1. This path takes precedence over every mode code.
- R3: `cfg_ext_div` values 00, 01, 10 and 11 pass one in every 1, 2, 4 and 8 external edges. After reset, the first count happens on the 1st, 2nd, 4th or 8th edge.
- R4: A level change on `xclk_in`, applied between clock edges, changes the count on the third following rising clock edge and not earlier. The two-flop resynchronizer accounts for two of those edges.
- R5: `cfg_trig_sel`=101 selects the channel-1 detector as the trigger, and 100 selects the internal link. Every other code yields no trigger.
- R6: `cfg_ch1_inv`=0 makes channel 1 active on its rising edge only. `cfg_ch1_inv`=1 makes it active on its falling edge only.
- R7: With `cfg_mode`=110 (trigger mode), a selected trigger edge takes HALT→RUN and sets `trig_flag`. External edges seen before that trigger are not counted.
- R8: With `cfg_mode`=111 and `cfg_ext_en`=0 (trigger-clock mode), the count advances once per selected trigger edge while in RUN. `trig_flag` is set by those edges.
- R9: With `cfg_ext_en`=0 and `cfg_mode` not 111, the count advances on every clock while in RUN. It wraps modulo 2^CNT_W.
- R10: `trig_flag` stays set until a `sw_flag_clr` strobe. A trigger edge in the same cycle as the clear wins.
- R11: `sw_stop` forces HALT on the next edge, and it overrides `sw_start` and triggers in the same cycle. `sw_start` enters RUN.
- R12: While `cnt_en` is 0 the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 3 | Slave mode code (110 trigger, 111 trigger-clock) |
| cfg_trig_sel | input | 3 | Trigger source code (101 channel 1, 100 internal link) |
| cfg_ext_en | input | 1 | Count on conditioned external pin edges |
| cfg_ext_inv | input | 1 | Invert external pin before edge detection |
| cfg_ext_div | input | 2 | External edge prescaler, divide by 2^code |
| cfg_ch1_inv | input | 1 | Invert channel-1 pin before edge detection |
| sw_start | input | 1 | Strobe: enter RUN |
| sw_stop | input | 1 | Strobe: enter HALT (dominant) |
| sw_flag_clr | input | 1 | Strobe: clear trigger flag |
| ch1_in | input | 1 | Raw channel-1 pin |
| xclk_in | input | 1 | Raw external clock pin |
| link_in | input | 1 | Internal trigger from companion timer |
| count | output | CNT_W | Counter value |
| cnt_en | output | 1 | High in RUN |
| trig_flag | output | 1 | Sticky trigger interrupt flag |

## Verification
The bench sweeps every polarity and prescaler combination of the external path and compares the count against the edge total shifted right by the divide code. An off-by-one prescaler, or a polarity that is ignored, would miscount in that sweep. It drives every trigger-select code against both trigger sources. A wrong decode would start the counter from an unselected input. The bench also pins the exact clock edge on which an external edge reaches the count, so a missing or extra resynchronizer stage is caught. It stages a same-cycle flag set and clear: a design that lets the clear win would drop an interrupt. It checks that the stop strobe overrides a trigger, that the falling edge of channel 1 is ignored at rising polarity, and that the counter wraps in a 4-bit configuration.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam logic [2:0] MODE_TRIGGER = 3'b110;
    localparam logic [2:0] MODE_TRGCLK  = 3'b111;
    localparam logic [2:0] SEL_LINK     = 3'b100;
    localparam logic [2:0] SEL_CH1      = 3'b101;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic invert,
    output logic rise
);
    logic [STAGES-1:0] sr;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            last <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], din ^ invert};
            last <= sr[STAGES-1];
        end
    end

    assign rise = sr[STAGES-1] & ~last;
endmodule

// File: rtl/tsc_etr_prescaler.sv
module tsc_etr_prescaler #(
    parameter int SEL_W = 2,
    localparam int PSC_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PSC_W-1:0] acc;
    logic [PSC_W-1:0] mask;

    always_comb begin
        mask = PSC_W'((32'd1 << sel) - 32'd1);
        tick = edge_in && ((acc & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc <= '0;
        else if (tick)    acc <= '0;
        else if (edge_in) acc <= acc + PSC_W'(1);
    end
endmodule

// File: rtl/tsc_ctrl_fsm.sv
module tsc_ctrl_fsm
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_edge,
    input  logic trig_mode,
    input  logic trgclk_mode,
    input  logic sw_start,
    input  logic sw_stop,
    input  logic sw_flag_clr,
    output logic cnt_en,
    output logic trig_flag
);
    run_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (!sw_stop && (sw_start || (trig_mode && trig_edge)))
                         state_nx = ST_RUN;
            ST_RUN:  if (sw_stop)
                         state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        trig_flag <= 1'b0;
        else if (trig_edge && (trig_mode || trgclk_mode))  trig_flag <= 1'b1;
        else if (sw_flag_clr)                              trig_flag <= 1'b0;
    end

    assign cnt_en = (state == ST_RUN);
endmodule

// File: rtl/tim_slave_ctrl.sv
module tim_slave_ctrl
    import tsc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_LEN = 2,
    parameter int DIV_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic [2:0]       cfg_trig_sel,
    input  logic             cfg_ext_en,
    input  logic             cfg_ext_inv,
    input  logic [DIV_W-1:0] cfg_ext_div,
    input  logic             cfg_ch1_inv,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             sw_flag_clr,
    input  logic             ch1_in,
    input  logic             xclk_in,
    input  logic             link_in,
    output logic [CNT_W-1:0] count,
    output logic             cnt_en,
    output logic             trig_flag
);
    localparam int N_SRC = 3;

    logic [N_SRC-1:0] raw_in, inv_in, src_rise;
    logic             ext_rise, ch1_rise, link_rise;
    logic             ext_tick, trig_edge, step;

    assign raw_in = {link_in, ch1_in, xclk_in};
    assign inv_in = {1'b0, cfg_ch1_inv, cfg_ext_inv};

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        tsc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (raw_in[g]),
            .invert (inv_in[g]),
            .rise   (src_rise[g])
        );
    end

    assign ext_rise  = src_rise[0];
    assign ch1_rise  = src_rise[1];
    assign link_rise = src_rise[2];

    tsc_etr_prescaler #(.SEL_W(DIV_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (ext_rise),
        .sel     (cfg_ext_div),
        .tick    (ext_tick)
    );

    always_comb begin
        unique case (cfg_trig_sel)
            SEL_CH1:  trig_edge = ch1_rise;
            SEL_LINK: trig_edge = link_rise;
            default:  trig_edge = 1'b0;
        endcase
    end

    tsc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_edge   (trig_edge),
        .trig_mode   (cfg_mode == MODE_TRIGGER),
        .trgclk_mode (cfg_mode == MODE_TRGCLK),
        .sw_start    (sw_start),
        .sw_stop     (sw_stop),
        .sw_flag_clr (sw_flag_clr),
        .cnt_en      (cnt_en),
        .trig_flag   (trig_flag)
    );

    always_comb begin
        if (cfg_ext_en)                    step = ext_tick;
        else if (cfg_mode == MODE_TRGCLK)  step = trig_edge;
        else                               step = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (cnt_en && step) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             cnt_en,
    input logic             trig_flag,
    input logic             sw_stop,
    input logic             sw_flag_clr,
    input logic [2:0]       cfg_mode,
    input logic             cfg_ext_en,
    input logic [DIV_W-1:0] cfg_ext_div,
    input logic             trig_edge,
    input logic             ext_rise
);
    assert_hold_when_halted_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));

    assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> ($stable(count) || count == $past(count) + CNT_W'(1)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !sw_flag_clr) |=> trig_flag);

    assert_stop_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !cnt_en);

    assert_ext_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cfg_ext_en && cfg_ext_div == '0 && ext_rise)
            |=> count == $past(count) + CNT_W'(1));

    assert_trigger_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && cfg_mode == 3'b110 && !sw_stop) |=> (cnt_en && trig_flag));
endmodule

bind tim_slave_ctrl tsc_checker #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (count),
    .cnt_en      (cnt_en),
    .trig_flag   (trig_flag),
    .sw_stop     (sw_stop),
    .sw_flag_clr (sw_flag_clr),
    .cfg_mode    (cfg_mode),
    .cfg_ext_en  (cfg_ext_en),
    .cfg_ext_div (cfg_ext_div),
    .trig_edge   (trig_edge),
    .ext_rise    (ext_rise)
);

// File: tb/tim_slave_ctrl_bench.sv
`timescale 1ns/1ps
module tim_slave_ctrl_bench;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'b000, cfg_trig_sel = 3'b000;
    logic cfg_ext_en = 1'b0, cfg_ext_inv = 1'b0, cfg_ch1_inv = 1'b0;
    logic [1:0] cfg_ext_div = 2'b00;
    logic sw_start = 1'b0, sw_stop = 1'b0, sw_flag_clr = 1'b0;
    logic ch1_in = 1'b0, xclk_in = 1'b0, link_in = 1'b0;
    logic [CNT_W-1:0] count;
    logic cnt_en, trig_flag;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tim_slave_ctrl #(.CNT_W(CNT_W)) u_tim_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_trig_sel(cfg_trig_sel),
        .cfg_ext_en(cfg_ext_en), .cfg_ext_inv(cfg_ext_inv), .cfg_ext_div(cfg_ext_div),
        .cfg_ch1_inv(cfg_ch1_inv), .sw_start(sw_start), .sw_stop(sw_stop),
        .sw_flag_clr(sw_flag_clr), .ch1_in(ch1_in), .xclk_in(xclk_in), .link_in(link_in),
        .count(count), .cnt_en(cnt_en), .trig_flag(trig_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic start_pulse();
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
    endtask

    task automatic ext_pulse();
        xclk_in = ~cfg_ext_inv; tick(3);
        xclk_in = cfg_ext_inv;  tick(3);
    endtask

    task automatic link_pulse();
        link_in = 1'b1; tick(3);
        link_in = 1'b0; tick(3);
    endtask

    task automatic ch1_pulse();
        ch1_in = ~cfg_ch1_inv; tick(3);
        ch1_in = cfg_ch1_inv;  tick(3);
    endtask

    initial begin
        tick(1);
        do_reset();
        check("R1 count", int'(count), 0);
        check("R1 cnt_en", int'(cnt_en), 0);
        check("R1 trig_flag", int'(trig_flag), 0);

        // R2 / R3: polarity and prescaler sweep
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 4; d++) begin
                cfg_mode = 3'b000; cfg_ext_en = 1'b1;
                cfg_ext_inv = p[0]; cfg_ext_div = d[1:0];
                xclk_in = p[0];
                do_reset();
                start_pulse();
                for (int e = 1; e <= 12; e++) begin
                    ext_pulse();
                    check($sformatf("R2 R3 inv=%0d div=%0d edge=%0d", p, d, e),
                          int'(count), e >> d);
                end
            end
        end

        // R4: exact latency
        cfg_ext_inv = 1'b0; cfg_ext_div = 2'b00; xclk_in = 1'b0;
        do_reset();
        start_pulse();
        xclk_in = 1'b1;
        tick(1); check("R4 edge1", int'(count), 0);
        tick(1); check("R4 edge2", int'(count), 0);
        tick(1); check("R4 edge3", int'(count), 1);
        xclk_in = 1'b0; tick(3);

        // R5: trigger-select decode against both sources
        for (int s = 0; s < 8; s++) begin
            for (int src = 0; src < 2; src++) begin
                cfg_mode = 3'b110; cfg_ext_en = 1'b1; cfg_trig_sel = s[2:0];
                cfg_ch1_inv = 1'b0; ch1_in = 1'b0; link_in = 1'b0;
                do_reset();
                if (src == 0) ch1_pulse(); else link_pulse();
                check($sformatf("R5 sel=%0d src=%0d cnt_en", s, src), int'(cnt_en),
                      ((s == 5 && src == 0) || (s == 4 && src == 1)) ? 1 : 0);
                check($sformatf("R5 sel=%0d src=%0d flag", s, src), int'(trig_flag),
                      ((s == 5 && src == 0) || (s == 4 && src == 1)) ? 1 : 0);
            end
        end

        // R6: channel-1 polarity
        cfg_mode = 3'b110; cfg_trig_sel = 3'b101; cfg_ch1_inv = 1'b1; ch1_in = 1'b1;
        do_reset();
        ch1_in = 1'b0; tick(4);
        check("R6 falling starts", int'(cnt_en), 1);
        sw_stop = 1'b1; sw_flag_clr = 1'b1; tick(1); sw_stop = 1'b0; sw_flag_clr = 1'b0;
        ch1_in = 1'b1; tick(4);
        check("R6 rising ignored cnt_en", int'(cnt_en), 0);
        check("R6 rising ignored flag", int'(trig_flag), 0);
        cfg_ch1_inv = 1'b0; ch1_in = 1'b0;
        do_reset();
        ch1_in = 1'b1; tick(4);
        check("R6 rising starts", int'(cnt_en), 1);
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        ch1_in = 1'b0; tick(4);
        check("R6 falling ignored", int'(cnt_en), 0);

        // R7: trigger start combined with external clock
        cfg_mode = 3'b110; cfg_trig_sel = 3'b101; cfg_ext_en = 1'b1;
        cfg_ext_inv = 1'b0; cfg_ext_div = 2'b00; xclk_in = 1'b0; ch1_in = 1'b0;
        do_reset();
        repeat (3) ext_pulse();
        check("R7 pre-trigger count", int'(count), 0);
        check("R7 pre-trigger cnt_en", int'(cnt_en), 0);
        ch1_pulse();
        check("R7 trigger cnt_en", int'(cnt_en), 1);
        check("R7 trigger flag", int'(trig_flag), 1);
        check("R7 trigger count", int'(count), 0);
        repeat (2) ext_pulse();
        check("R7 post-trigger count", int'(count), 2);

        // R8: trigger-clock mode on internal link
        cfg_mode = 3'b111; cfg_trig_sel = 3'b100; cfg_ext_en = 1'b0; link_in = 1'b0;
        do_reset();
        start_pulse();
        repeat (9) link_pulse();
        check("R8 count", int'(count), 9);
        check("R8 flag", int'(trig_flag), 1);

        // R9: free count with wrap; R11 / R12 stop and hold
        cfg_mode = 3'b000; cfg_ext_en = 1'b0;
        do_reset();
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        check("R11 start", int'(cnt_en), 1);
        check("R9 count at start", int'(count), 0);
        tick(20);
        check("R9 wrap", int'(count), 20 % 16);
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        check("R11 stop", int'(cnt_en), 0);
        check("R9 last step", int'(count), 5);
        tick(5);
        check("R12 hold", int'(count), 5);

        // R11: stop overrides trigger
        cfg_mode = 3'b110; cfg_trig_sel = 3'b100; link_in = 1'b0;
        do_reset();
        sw_stop = 1'b1; link_pulse(); sw_stop = 1'b0; tick(1);
        check("R11 stop beats trigger", int'(cnt_en), 0);
        check("R12 hold while stopped", int'(count), 0);

        // R10: sticky flag, clear, and set winning over clear
        check("R10 flag set", int'(trig_flag), 1);
        tick(6);
        check("R10 flag sticky", int'(trig_flag), 1);
        sw_flag_clr = 1'b1; tick(1); sw_flag_clr = 1'b0;
        check("R10 flag cleared", int'(trig_flag), 0);
        link_in = 1'b1; tick(2);
        sw_flag_clr = 1'b1; tick(1); sw_flag_clr = 1'b0;
        check("R10 set beats clear", int'(trig_flag), 1);
        link_in = 1'b0; tick(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule